// File: doc/BRIEF.md
# Shared Cell Buffer Admission Manager

This block decides whether a packet may enter the shared cell memory of a multi-port store-and-forward switch. An ingress port presents a request with the packet length in cells and a mask of destination ports. The manager charges the cells first against the reserved quota of one destination port. Any cells beyond that quota come from a common pool. If the pool cannot cover the remainder, the packet is refused before anything is written. A granted packet receives a buffer handle, and it keeps that handle until it is released.

A packet bound for several ports occupies the memory once. Its handle carries a count of the outstanding readers. Each egress port reports a read completion against the handle, and the last completion returns the cells exactly to the quota and pool parts they were taken from. A flow-control pause request rises when total occupancy reaches a high-water mark. It stays up until occupancy drops to a lower low-water mark.

Top module: `sbuf_admit_mgr`

## Requirements
- R1: After reset, no grant or refusal is signalled, the pause request is low, every handle is free and every counter is empty, so the first valid request is granted handle 0.
- R2: A request taken on a clock edge yields, one cycle later, exactly one one-cycle pulse: either grant together with its handle, or refuse. With no request there is no pulse.
- R3: A grant always returns the lowest-numbered free handle. When all NHANDLES handles are in use, the request is refused.
- R4: The port charged for a packet is the lowest set bit of its destination mask. Cells are taken from that port's RES_CELLS reserved quota as far as it has room.
- R5: Cells beyond the reserved room come from the POOL_CELLS common pool. If the pool lacks room, the packet is refused, and a refused packet changes no counter and no handle.
- R6: A request with length 0, length above MAX_LEN, or an all-zero mask is refused.
- R7: A granted handle holds a reader count equal to the number of set mask bits. Each read completion on a live handle lowers that count by one, and at zero the handle becomes free.
- R8: Freeing a handle returns exactly the reserved cells to the charged port and exactly the pool cells to the pool, as they were split at grant.
- R9: A read completion that names a free handle has no effect.
- R10: The pause request is updated on the same edge as occupancy. It is set when the new occupancy is at or above HI_MARK, cleared when it is at or below LO_MARK, and held otherwise.
- R11: When a release and a request arrive in the same cycle, the request is judged on the counters and handles as they stood before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adm_req | input | 1 | Admission request valid |
| adm_len | input | LENW | Packet length in cells |
| adm_mask | input | NPORTS | Destination port mask |
| adm_grant | output | 1 | Packet admitted (one cycle after request) |
| adm_refuse | output | 1 | Packet refused (one cycle after request) |
| adm_handle | output | HW | Buffer handle given with a grant |
| rd_done | input | 1 | One destination finished reading a packet |
| rd_handle | input | HW | Handle the read completion refers to |
| pause_req | output | 1 | Ask senders to pause |

## Verification
A miscounted reserved or pool counter does not show at once. It appears as a wrong grant or refusal on the next request that charges that port or needs the pool, and that request may come many cycles later. A wrong reader count or a leaked handle shows up as a handle number that differs from the lowest free one, or as early refusals once handles run out. An occupancy error shows most quickly, because the pause request moves on the very edge that occupancy crosses a mark. For that reason, the bench compares grant, refusal, handle and pause on every cycle against an independent model.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        RESP_IDLE   = 2'd0,
        RESP_GRANT  = 2'd1,
        RESP_REFUSE = 2'd2
    } resp_e;

endpackage

// File: rtl/sbuf_quota.sv
module sbuf_quota #(
    parameter int NPORTS     = 4,
    parameter int RES_CELLS  = 4,
    parameter int POOL_CELLS = 16,
    parameter int LENW       = 5,
    parameter int PW         = 2,
    parameter int CNTW       = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PW-1:0]   chk_port,
    input  logic [LENW-1:0] chk_len,
    output logic [CNTW-1:0] chk_res,
    output logic [CNTW-1:0] chk_pool,
    output logic            chk_fits,
    input  logic            commit_en,
    input  logic            rel_en,
    input  logic [PW-1:0]   rel_port,
    input  logic [CNTW-1:0] rel_res,
    input  logic [CNTW-1:0] rel_pool,
    output logic [CNTW-1:0] occ,
    output logic [CNTW-1:0] occ_next
);

    logic [CNTW-1:0] res_used [NPORTS];
    logic [CNTW-1:0] pool_used;
    logic [CNTW-1:0] len_c, rfree, pfree;

    always_comb begin
        len_c    = CNTW'(chk_len);
        rfree    = CNTW'(RES_CELLS) - res_used[chk_port];
        chk_res  = (len_c < rfree) ? len_c : rfree;
        chk_pool = len_c - chk_res;
        pfree    = CNTW'(POOL_CELLS) - pool_used;
        chk_fits = (chk_pool <= pfree);
    end

    always_comb begin
        occ_next = occ;
        if (commit_en) occ_next = occ_next + chk_res + chk_pool;
        if (rel_en)    occ_next = occ_next - rel_res - rel_pool;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPORTS; p++) res_used[p] <= '0;
            pool_used <= '0;
            occ       <= '0;
        end else begin
            for (int p = 0; p < NPORTS; p++) begin
                res_used[p] <= res_used[p]
                    + ((commit_en && chk_port == PW'(p)) ? chk_res : '0)
                    - ((rel_en && rel_port == PW'(p)) ? rel_res : '0);
            end
            pool_used <= pool_used
                + (commit_en ? chk_pool : '0)
                - (rel_en ? rel_pool : '0);
            occ <= occ_next;
        end
    end

endmodule

// File: rtl/sbuf_htab.sv
module sbuf_htab #(
    parameter int NHANDLES = 8,
    parameter int PW       = 2,
    parameter int HW       = 3,
    parameter int CNTW     = 6,
    parameter int RCW      = 3
) (
    input  logic            clk,
    input  logic            rst,
    output logic            free_avail,
    output logic [HW-1:0]   free_idx,
    input  logic            alloc_en,
    input  logic [PW-1:0]   alloc_port,
    input  logic [CNTW-1:0] alloc_res,
    input  logic [CNTW-1:0] alloc_pool,
    input  logic [RCW-1:0]  alloc_refs,
    input  logic            dec_en,
    input  logic [HW-1:0]   dec_idx,
    output logic            rel_en,
    output logic [PW-1:0]   rel_port,
    output logic [CNTW-1:0] rel_res,
    output logic [CNTW-1:0] rel_pool
);

    typedef struct packed {
        logic [PW-1:0]   port;
        logic [CNTW-1:0] res;
        logic [CNTW-1:0] pool;
        logic [RCW-1:0]  refs;
    } hrec_t;

    hrec_t               rec [NHANDLES];
    logic [NHANDLES-1:0] live;
    hrec_t               cur;
    logic                hit;

    always_comb begin
        free_idx   = '0;
        free_avail = 1'b0;
        for (int i = NHANDLES - 1; i >= 0; i--) begin
            if (!live[i]) begin
                free_idx   = HW'(i);
                free_avail = 1'b1;
            end
        end
    end

    always_comb begin
        cur      = rec[dec_idx];
        hit      = dec_en && live[dec_idx];
        rel_en   = hit && (cur.refs == RCW'(1));
        rel_port = cur.port;
        rel_res  = cur.res;
        rel_pool = cur.pool;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            for (int i = 0; i < NHANDLES; i++) rec[i] <= '0;
        end else begin
            if (alloc_en) begin
                live[free_idx] <= 1'b1;
                rec[free_idx]  <= '{port: alloc_port, res: alloc_res,
                                    pool: alloc_pool, refs: alloc_refs};
            end
            if (hit) begin
                rec[dec_idx].refs <= cur.refs - RCW'(1);
                if (rel_en) live[dec_idx] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sbuf_pause.sv
module sbuf_pause #(
    parameter int CNTW    = 6,
    parameter int HI_MARK = 24,
    parameter int LO_MARK = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CNTW-1:0] occ_next,
    output logic            pause
);

    always_ff @(posedge clk) begin
        if (rst)                              pause <= 1'b0;
        else if (occ_next >= CNTW'(HI_MARK))  pause <= 1'b1;
        else if (occ_next <= CNTW'(LO_MARK))  pause <= 1'b0;
    end

endmodule

// File: rtl/sbuf_admit_mgr.sv
module sbuf_admit_mgr
    import sbuf_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int NHANDLES   = 8,
    parameter int RES_CELLS  = 4,
    parameter int POOL_CELLS = 16,
    parameter int MAX_LEN    = 16,
    parameter int HI_MARK    = 24,
    parameter int LO_MARK    = 12,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int HW    = (NHANDLES > 1) ? $clog2(NHANDLES) : 1,
    localparam int LENW  = $clog2(MAX_LEN + 1),
    localparam int TOTAL = NPORTS * RES_CELLS + POOL_CELLS,
    localparam int CNTW  = $clog2(TOTAL + 1),
    localparam int RCW   = $clog2(NPORTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adm_req,
    input  logic [LENW-1:0]   adm_len,
    input  logic [NPORTS-1:0] adm_mask,
    output logic              adm_grant,
    output logic              adm_refuse,
    output logic [HW-1:0]     adm_handle,
    input  logic              rd_done,
    input  logic [HW-1:0]     rd_handle,
    output logic              pause_req
);

    logic [PW-1:0]   chg_port;
    logic [RCW-1:0]  n_refs;
    logic [CNTW-1:0] chk_res, chk_pool;
    logic            chk_fits, free_avail, len_ok, accept;
    logic [HW-1:0]   free_idx;
    logic            rel_en;
    logic [PW-1:0]   rel_port;
    logic [CNTW-1:0] rel_res, rel_pool;
    logic [CNTW-1:0] occ_cells, occ_next;
    resp_e           resp_q;
    logic [HW-1:0]   hnd_q;

    always_comb begin
        chg_port = '0;
        for (int i = NPORTS - 1; i >= 0; i--)
            if (adm_mask[i]) chg_port = PW'(i);
        n_refs = RCW'($countones(adm_mask));
        len_ok = (adm_len != '0) && (adm_len <= LENW'(MAX_LEN));
        accept = adm_req && len_ok && (|adm_mask) && chk_fits && free_avail;
    end

    sbuf_quota #(
        .NPORTS(NPORTS), .RES_CELLS(RES_CELLS), .POOL_CELLS(POOL_CELLS),
        .LENW(LENW), .PW(PW), .CNTW(CNTW)
    ) u_quota (
        .clk(clk), .rst(rst),
        .chk_port(chg_port), .chk_len(adm_len),
        .chk_res(chk_res), .chk_pool(chk_pool), .chk_fits(chk_fits),
        .commit_en(accept),
        .rel_en(rel_en), .rel_port(rel_port), .rel_res(rel_res), .rel_pool(rel_pool),
        .occ(occ_cells), .occ_next(occ_next)
    );

    sbuf_htab #(
        .NHANDLES(NHANDLES), .PW(PW), .HW(HW), .CNTW(CNTW), .RCW(RCW)
    ) u_htab (
        .clk(clk), .rst(rst),
        .free_avail(free_avail), .free_idx(free_idx),
        .alloc_en(accept), .alloc_port(chg_port),
        .alloc_res(chk_res), .alloc_pool(chk_pool), .alloc_refs(n_refs),
        .dec_en(rd_done), .dec_idx(rd_handle),
        .rel_en(rel_en), .rel_port(rel_port), .rel_res(rel_res), .rel_pool(rel_pool)
    );

    sbuf_pause #(
        .CNTW(CNTW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
    ) u_pause (
        .clk(clk), .rst(rst), .occ_next(occ_next), .pause(pause_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= RESP_IDLE;
            hnd_q  <= '0;
        end else begin
            resp_q <= !adm_req ? RESP_IDLE : (accept ? RESP_GRANT : RESP_REFUSE);
            hnd_q  <= accept ? free_idx : '0;
        end
    end

    assign adm_grant  = (resp_q == RESP_GRANT);
    assign adm_refuse = (resp_q == RESP_REFUSE);
    assign adm_handle = hnd_q;

endmodule

// File: rtl/sbuf_admit_chk.sv
module sbuf_admit_chk #(
    parameter int NPORTS  = 4,
    parameter int LENW    = 5,
    parameter int CNTW    = 6,
    parameter int TOTAL   = 32,
    parameter int HI_MARK = 24,
    parameter int LO_MARK = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              adm_req,
    input logic [LENW-1:0]   adm_len,
    input logic [NPORTS-1:0] adm_mask,
    input logic              adm_grant,
    input logic              adm_refuse,
    input logic              pause_req,
    input logic [CNTW-1:0]   occ
);

    assert_single_resp_R2: assert property (@(posedge clk) disable iff (rst)
        !(adm_grant && adm_refuse));

    assert_resp_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        (adm_grant || adm_refuse) |-> $past(adm_req));

    assert_req_gets_resp_R2: assert property (@(posedge clk) disable iff (rst)
        adm_req |=> (adm_grant || adm_refuse));

    assert_no_grant_bad_req_R6: assert property (@(posedge clk) disable iff (rst)
        adm_grant |-> ($past(adm_mask) != '0 && $past(adm_len) != '0));

    assert_occ_bound_R5: assert property (@(posedge clk) disable iff (rst)
        occ <= CNTW'(TOTAL));

    assert_pause_high_R10: assert property (@(posedge clk) disable iff (rst)
        (occ >= CNTW'(HI_MARK)) |-> pause_req);

    assert_pause_low_R10: assert property (@(posedge clk) disable iff (rst)
        (occ <= CNTW'(LO_MARK)) |-> !pause_req);

endmodule

bind sbuf_admit_mgr sbuf_admit_chk #(
    .NPORTS(NPORTS), .LENW(LENW), .CNTW(CNTW), .TOTAL(TOTAL),
    .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
) u_chk (
    .clk(clk), .rst(rst), .adm_req(adm_req), .adm_len(adm_len),
    .adm_mask(adm_mask), .adm_grant(adm_grant), .adm_refuse(adm_refuse),
    .pause_req(pause_req), .occ(occ_cells)
);

// File: tb/sim_sbuf_admit_mgr.sv
`timescale 1ns/1ps
module sim_sbuf_admit_mgr;

    localparam int NP = 4, NH = 8, RES = 4, POOL = 16, MAXL = 16, HI = 24, LO = 12;

    logic       clk = 1'b0, rst = 1'b1;
    logic       adm_req = 1'b0, rd_done = 1'b0;
    logic [4:0] adm_len = '0;
    logic [3:0] adm_mask = '0;
    logic [2:0] rd_handle = '0, adm_handle;
    logic       adm_grant, adm_refuse, pause_req;

    int checks = 0, fails = 0;
    bit done = 0;

    int m_res [NP];
    int m_pool;
    bit m_live [NH];
    int m_refs [NH], m_port [NH], m_r [NH], m_p [NH];
    bit m_pause;

    always #2.5 clk = ~clk;

    sbuf_admit_mgr u0 (
        .clk(clk), .rst(rst), .adm_req(adm_req), .adm_len(adm_len),
        .adm_mask(adm_mask), .adm_grant(adm_grant), .adm_refuse(adm_refuse),
        .adm_handle(adm_handle), .rd_done(rd_done), .rd_handle(rd_handle),
        .pause_req(pause_req)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int occupancy();
        int s = m_pool;
        for (int p = 0; p < NP; p++) s += m_res[p];
        return s;
    endfunction

    // Called at a falling edge; drives one cycle and checks after the next rise.
    task automatic step(bit req, int len, int mask, bit rd, int rh, string tag);
        int hfree, port, rfree, tr, tp, occ;
        bit ok;
        adm_req = req; adm_len = 5'(len); adm_mask = 4'(mask);
        rd_done = rd; rd_handle = 3'(rh);
        // decision on state before any release (R11)
        hfree = -1;
        for (int i = NH - 1; i >= 0; i--) if (!m_live[i]) hfree = i;
        port = 0;
        for (int i = NP - 1; i >= 0; i--) if (mask[i]) port = i;
        rfree = RES - m_res[port];
        tr = (len < rfree) ? len : rfree;
        tp = len - tr;
        ok = req && len >= 1 && len <= MAXL && mask != 0 && hfree >= 0 && tp <= POOL - m_pool;
        if (rd && m_live[rh]) begin
            if (m_refs[rh] == 1) begin
                m_live[rh] = 0;
                m_res[m_port[rh]] -= m_r[rh];
                m_pool -= m_p[rh];
            end
            m_refs[rh]--;
        end
        if (ok) begin
            m_live[hfree] = 1; m_refs[hfree] = $countones(4'(mask));
            m_port[hfree] = port; m_r[hfree] = tr; m_p[hfree] = tp;
            m_res[port] += tr; m_pool += tp;
        end
        occ = occupancy();
        if (occ >= HI) m_pause = 1;
        else if (occ <= LO) m_pause = 0;
        @(negedge clk);
        chk(tag, "grant", int'(adm_grant), int'(ok));
        chk(tag, "refuse", int'(adm_refuse), int'(req && !ok));
        if (ok) chk(tag, "handle", int'(adm_handle), hfree);
        chk(tag, "pause", int'(pause_req), int'(m_pause));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        for (int p = 0; p < NP; p++) m_res[p] = 0;
        m_pool = 0; m_pause = 0;
        for (int i = 0; i < NH; i++) begin
            m_live[i] = 0; m_refs[i] = 0; m_port[i] = 0; m_r[i] = 0; m_p[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk("R1", "grant", int'(adm_grant), 0);
        chk("R1", "refuse", int'(adm_refuse), 0);
        chk("R1", "pause", int'(pause_req), 0);
        // R1 R3 R4: first packet gets handle 0, charged to port 0 reserve
        step(1, 3, 4'b0001, 0, 0, "R4");
        // R5: reserve of port 0 has 1 left, 3 go to pool
        step(1, 4, 4'b0001, 0, 0, "R5");
        // R6: illegal requests refused
        step(1, 0, 4'b0010, 0, 0, "R6");
        step(1, 17, 4'b0010, 0, 0, "R6");
        step(1, 5, 4'b0000, 0, 0, "R6");
        // R2: no request, no pulse
        step(0, 5, 4'b0010, 0, 0, "R2");
        // R7: multicast to ports 1 and 3, charged to port 1
        step(1, 2, 4'b1010, 0, 0, "R7");
        step(0, 0, 0, 1, 2, "R7");
        step(1, 1, 4'b0100, 0, 0, "R7");   // handle 2 still live: gets 3
        step(0, 0, 0, 1, 2, "R7");
        step(1, 1, 4'b0100, 0, 0, "R3");   // handle 2 now free
        // R9: completion on a free handle
        step(0, 0, 0, 1, 6, "R9");
        // R5 R10: fill pool and reserves toward the high mark
        step(1, 16, 4'b1000, 0, 0, "R10");
        step(1, 16, 4'b0100, 0, 0, "R5");
        step(1, 4, 4'b0010, 0, 0, "R10");
        // R11: release of handle 1 coincides with a request needing its pool cells
        step(1, 8, 4'b0001, 1, 1, "R11");
        step(1, 8, 4'b0001, 0, 0, "R8");
        // R10: drain to clear pause
        for (int h = 0; h < NH; h++) begin
            step(0, 0, 0, 1, h, "R10");
            step(0, 0, 0, 1, h, "R10");
        end
        // R3: exhaust handles with single-cell packets
        for (int k = 0; k < NH + 2; k++) step(1, 1, 4'b0001 << (k % NP), 0, 0, "R3");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            int len, mask, rh;
            bit req, rd;
            req  = ($urandom % 3) != 0;
            len  = (($urandom % 8) == 0) ? ($urandom % 19) : 1 + ($urandom % 8);
            mask = (($urandom % 10) == 0) ? 0 : ($urandom % 16);
            rd   = ($urandom % 4) != 0;
            rh   = $urandom % NH;
            step(req, len, mask, rd, rh, "R8");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule